// File: doc/BRIEF.md
# Gated Bit-Stream Window Counter

This block measures the duty of a one-bit modulator output by counting, inside a repeating measurement window, the clock cycles in which the stream is high. A free-running phase counter builds the window internally from two inputs: a period and a high time. Only while the window is high does a high stream bit advance the count. The count therefore grows with the stream's duty, and a sensor with more capacitance drives a denser stream, so it produces a larger result.

On the last high cycle of each window, the count, including that final cycle, is moved into a result register. In the same cycle the running counter returns to zero and a one-cycle valid pulse marks the update. Each result therefore covers exactly one window: no cycle is lost at the boundary and none is counted twice. A host or a downstream filter reads the result on the valid pulse. The window itself is also driven out, so external logic can align to it.

Top module: `bstream_window_counter`

## Requirements
- R1: `window_out` is high while the internal phase is below `win_high`. The phase steps 0, 1, … up to `win_period`−1 and then wraps to 0. A period of 0 or 1 holds the phase at 0. If the period is lowered below the current phase, the phase returns to 0 on the next cycle.
- R2: The running count increases by one only on cycles where `bit_in` and the window are both high. On all other cycles, except the window's last high cycle, it holds its value.
- R3: A window's last high cycle is the cycle in which the window is high and the next phase falls outside it. On the edge that ends this cycle, `count_out` takes the running count plus that cycle's gated bit.
- R4: On the same edge the running count is cleared, so the next window starts from zero.
- R5: `count_valid` is high for exactly the one cycle that follows each result update. `count_out` keeps its value in every other cycle, and `count_valid` is never high in two consecutive cycles.
- R6: Both the running count and the captured value saturate at 2^CNT_W−1 and never wrap.
- R7: With `win_high` of 0, or `win_high` ≥ `win_period`, the window never falls. No `count_valid` pulse is produced and `count_out` holds.
- R8: During synchronous reset the phase, running count, `count_out` and `count_valid` are all 0.
- R9: A stream that is high on every cycle yields a result equal to the window's high time (below saturation). A stream that is always low yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the modulator latch |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Modulator bit stream |
| win_period | input | PER_W | Window repetition period in cycles |
| win_high | input | PER_W | Cycles per period in which the window is high |
| count_out | output | CNT_W | Count captured from the last completed window |
| count_valid | output | 1 | One-cycle pulse on each `count_out` update |
| window_out | output | 1 | Measurement window |

## Verification
A phase register that drifts shows up on `window_out` in the very next sample. It also moves the valid pulse away from the window's falling edge. A counter that is not cleared at the boundary, or that misses the boundary cycle, leaves `count_out` off by at least one at the first pulse after the fault. A counter that wraps instead of saturating shows a small value where the maximum is expected. An extra or missing valid pulse is seen in the cycle it happens, because every cycle is compared with a reference built from the requirements.

// File: rtl/bswc_pkg.sv
package bswc_pkg;

    typedef enum logic [1:0] {
        WIN_OFF  = 2'd0,
        WIN_ON   = 2'd1,
        WIN_LAST = 2'd2
    } win_state_e;

    // Next phase of the window timebase; periods 0 and 1 pin the phase at 0.
    function automatic logic [31:0] phase_step(input logic [31:0] ph,
                                               input logic [31:0] per);
        if (per <= 32'd1 || ph >= per - 32'd1)
            return 32'd0;
        return ph + 32'd1;
    endfunction

    // Saturating conditional increment.
    function automatic logic [31:0] sat_inc(input logic [31:0] v,
                                            input logic [31:0] maxv,
                                            input logic        inc);
        if (!inc)
            return v;
        if (v >= maxv)
            return maxv;
        return v + 32'd1;
    endfunction

endpackage

// File: rtl/bswc_window_gen.sv
module bswc_window_gen
    import bswc_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] high_time,
    output logic             win_o,
    output logic             last_o,
    output win_state_e       state_o
);

    logic [PER_W-1:0] ph_q;
    logic [PER_W-1:0] ph_n;
    logic             win_next;

    always_comb begin
        ph_n     = PER_W'(phase_step(32'(ph_q), 32'(period)));
        win_o    = (ph_q < high_time);
        win_next = (ph_n < high_time);
        last_o   = win_o && !win_next;
        if (last_o)
            state_o = WIN_LAST;
        else if (win_o)
            state_o = WIN_ON;
        else
            state_o = WIN_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else
            ph_q <= ph_n;
    end

    // R1: a phase at or past the period must wrap on the next edge
    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (ph_q >= period) |=> (ph_q == '0));

    // R1: inside the period the phase advances by one
    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        (period > PER_W'(1) && ph_q < period - PER_W'(1)) |=> (ph_q == $past(ph_q) + PER_W'(1)));

endmodule

// File: rtl/bswc_gated_counter.sv
module bswc_gated_counter
    import bswc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  win_state_e       win_state,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] close_val_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             gate;
    logic             closing;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        gate        = bit_in && (win_state != WIN_OFF);
        closing     = (win_state == WIN_LAST);
        close_val_o = CNT_W'(sat_inc(32'(cnt_q), 32'(CNT_MAX), gate));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (closing)
            cnt_q <= '0;
        else
            cnt_q <= close_val_o;
    end

    assign count_o = cnt_q;

    // R4: the last window cycle clears the running count
    p_clear_at_close_r4: assert property (@(posedge clk) disable iff (rst)
        closing |=> (cnt_q == '0));

    // R2: no gated bit, no change
    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!gate && !closing) |=> (cnt_q == $past(cnt_q)));

    // R2: a gated bit below the ceiling advances by exactly one
    p_step_when_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (gate && !closing && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R6: the ceiling is sticky until the window closes
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !closing) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/bswc_capture.sv
module bswc_capture
    import bswc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  win_state_e       win_state,
    input  logic [CNT_W-1:0] close_val,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             valid;
    } capture_t;

    capture_t cap_q;
    capture_t cap_n;

    always_comb begin
        cap_n       = cap_q;
        cap_n.valid = 1'b0;
        if (win_state == WIN_LAST) begin
            cap_n.value = close_val;
            cap_n.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else
            cap_q <= cap_n;
    end

    assign result_o = cap_q.value;
    assign valid_o  = cap_q.valid;

    // R5: valid is a single-cycle pulse
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R5: the result only moves together with a valid pulse
    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o));

endmodule

// File: rtl/bstream_window_counter.sv
module bstream_window_counter
    import bswc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic [PER_W-1:0] win_period,
    input  logic [PER_W-1:0] win_high,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid,
    output logic             window_out
);

    win_state_e       wstate;
    logic             win;
    logic             last;
    logic [CNT_W-1:0] running;
    logic [CNT_W-1:0] close_val;

    bswc_window_gen #(.PER_W(PER_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .period    (win_period),
        .high_time (win_high),
        .win_o     (win),
        .last_o    (last),
        .state_o   (wstate)
    );

    bswc_gated_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .bit_in      (bit_in),
        .win_state   (wstate),
        .count_o     (running),
        .close_val_o (close_val)
    );

    bswc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .win_state (wstate),
        .close_val (close_val),
        .result_o  (count_out),
        .valid_o   (count_valid)
    );

    assign window_out = win;

    // R3: a valid pulse always follows a cycle in which the window was high
    p_valid_after_window_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(count_valid) |-> $past(win));

    // R7: a window that never closes raises no valid pulse
    p_no_close_r7: assert property (@(posedge clk) disable iff (rst)
        (win_high == '0 || win_high >= win_period) |=> !count_valid);

    // R4: the capture edge leaves the running count at zero
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        count_valid |-> (running == '0));

endmodule

// File: tb/bstream_window_counter_test.sv
module bstream_window_counter_test;

    localparam int CNT_W = 6;
    localparam int PER_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             bit_in;
    logic [PER_W-1:0] win_period;
    logic [PER_W-1:0] win_high;
    logic [CNT_W-1:0] count_out;
    logic             count_valid;
    logic             window_out;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    int m_ph, m_cnt, m_res;
    bit m_done;
    int seen_pulses;
    int seen_val;
    bit in_no_close;

    always #4 clk = ~clk;

    bstream_window_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .bit_in      (bit_in),
        .win_period  (win_period),
        .win_high    (win_high),
        .count_out   (count_out),
        .count_valid (count_valid),
        .window_out  (window_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    // Reference step from the requirements (R1..R6)
    task automatic model_step(input bit b, input int per, input int hi);
        bit w, last, g;
        int nph;
        w    = (m_ph < hi);
        nph  = (per <= 1 || m_ph >= per - 1) ? 0 : m_ph + 1;
        last = w && !(nph < hi);
        g    = b && w;
        if (last) begin
            m_res  = sat(m_cnt + int'(g));  // R3 includes the closing cycle
            m_cnt  = 0;                     // R4 restart
            m_done = 1'b1;
        end else begin
            m_done = 1'b0;
            m_cnt  = sat(m_cnt + int'(g));  // R2 gated count, R6 ceiling
        end
        m_ph = nph;
    endtask

    task automatic compare_ports();
        check(window_out == (m_ph < int'(win_high)), "R1 window",
              int'(window_out), int'(m_ph < int'(win_high)));
        check(count_valid == m_done, in_no_close ? "R7 valid" : "R5 valid",
              int'(count_valid), int'(m_done));
        check(int'(count_out) == m_res, "R3 result", int'(count_out), m_res);
        if (count_valid) begin
            seen_pulses++;
            seen_val = int'(count_out);
        end
    endtask

    task automatic cyc(input bit b, input int per, input int hi);
        @(negedge clk);
        compare_ports();
        bit_in     = b;
        win_period = PER_W'(per);
        win_high   = PER_W'(hi);
        model_step(b, per, hi);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int stored;
        void'($urandom(32'd20240611));
        rst = 1'b1; bit_in = 1'b0;
        win_period = PER_W'(10); win_high = PER_W'(6);
        m_ph = 0; m_cnt = 0; m_res = 0; m_done = 0;
        seen_pulses = 0; seen_val = 0; in_no_close = 0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(count_out == '0, "R8 result", int'(count_out), 0);
        check(count_valid == 1'b0, "R8 valid", int'(count_valid), 0);
        check(window_out == 1'b1, "R8 phase", int'(window_out), 1);
        rst = 1'b0;
        model_step(1'b0, 10, 6);

        // R9 all-ones stream: result equals high time
        repeat (40) cyc(1'b1, 10, 6);
        check(seen_pulses >= 3, "R9 pulses", seen_pulses, 3);
        check(seen_val == 6, "R9 all ones", seen_val, 6);

        // R9 all-zero stream: result 0
        repeat (30) cyc(1'b0, 10, 6);
        check(seen_val == 0, "R9 all zeros", seen_val, 0);

        // R1 single-cycle window with period 2
        seen_pulses = 0;
        repeat (20) cyc(1'b1, 2, 1);
        check(seen_pulses >= 9, "R5 period-2 pulses", seen_pulses, 9);
        check(seen_val == 1, "R3 one-cycle window", seen_val, 1);

        // R6 saturation
        repeat (450) cyc(1'b1, 200, 100);
        check(seen_val == CMAX, "R6 saturation", seen_val, CMAX);

        // R7 window never falls: high >= period, then high == 0
        repeat (5) cyc(1'b1, 200, 100);
        while (m_ph != 0) cyc(1'b1, 200, 100);
        stored = int'(count_out);
        seen_pulses = 0;
        in_no_close = 1;
        repeat (60) cyc(1'b1, 8, 8);
        repeat (60) cyc(1'b1, 8, 0);
        repeat (60) cyc(1'b1, 1, 1);
        in_no_close = 0;
        @(negedge clk);
        compare_ports();
        check(seen_pulses == 0, "R7 no pulses", seen_pulses, 0);
        check(int'(count_out) == stored, "R7 result held", int'(count_out), stored);

        // R2 R4 random windows and duties
        begin
            int per, hi, duty;
            per = 12; hi = 7; duty = 50;
            for (int i = 0; i < 5000; i++) begin
                if ($urandom_range(0, 59) == 0) begin
                    per  = $urandom_range(0, 40);
                    hi   = $urandom_range(0, 45);
                    duty = 25 * $urandom_range(0, 4);
                end
                cyc($urandom_range(0, 99) < duty, per, hi);
            end
        end

        @(negedge clk);
        compare_ports();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule